// File: doc/BRIEF.md
# Fifteen-Cent Coin Credit Controller

This block controls the release mechanism of a drink dispenser that charges 15 cents. A coin sensor sends it one-cycle pulses, one line for nickels and one for dimes. The block adds up the credit and raises a release signal once the credit reaches the price. Pennies and quarters are not accepted, and the block never gives change. If a payment goes past the price, the extra credit is dropped.

Credit is held in one-hot form in four flip-flops, one flip-flop per credit level: `CR_0C`, `CR_5C`, `CR_10C` and `CR_15C`. The transitions are as follows:

- **idle hold:** with no coin, the block stays in any state.
- **nickel step:** `CR_0C`→`CR_5C`, `CR_5C`→`CR_10C` and `CR_10C`→`CR_15C`.
- **dime step:** `CR_0C`→`CR_10C` and `CR_5C`→`CR_15C`.
- **dime overpay:** `CR_10C`→`CR_15C`.
- **dispense latch:** `CR_15C`→`CR_15C` whatever coins arrive.
- **reset entry:** any state goes to `CR_0C`.

The release output is the `CR_15C` flip-flop itself. A diagnostic output goes high whenever the state vector does not hold exactly one set bit.

Top module: `coin_vend_ctrl`

## Requirements
- R1: When `rst` is high at a rising edge, the block enters `CR_0C` (state bits 0001). `open_o` is low from that edge until the price is paid again.
- R2: After reset, the state vector always holds exactly one set bit, and `state_bad_o` stays low.
- R3: In a cycle with neither coin line high, the credit does not change.
- R4: A nickel pulse with no dime adds 5 cents: 0→5, 5→10 and 10→15.
- R5: A dime pulse adds 10 cents from 0 (to 10) and from 5 (to 15).
- R6: A dime with 10 cents of credit gives 15 cents. The extra 5 cents is dropped.
- R7: `open_o` is high exactly while the credit is 15 cents. It rises at the edge that takes in the coin completing the price.
- R8: Once `open_o` is high, it stays high whatever coins arrive, until reset.
- R9: A cycle with both coin lines high counts as a single dime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle nickel pulse from the coin sensor |
| dime_i | input | 1 | One-cycle dime pulse from the coin sensor |
| open_o | output | 1 | Release command, high at 15 cents of credit |
| state_bad_o | output | 1 | High when the state vector is not one-hot |

## Verification
The bound assertions check the following on every cycle:

- the one-hot invariant and the low diagnostic flag;
- credit holding on idle cycles;
- each nickel and dime step out of the empty state;
- the dime overpay and the both-lines-high case;
- the latch of the release output.

Only the bench scenarios can show that the release comes after the right number of coins and not before. They compare `open_o` against a credit-counter model over directed coin orders and long random streams with occasional resets.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int CREDIT_LEVELS = 4;
    localparam int TOP_IDX       = CREDIT_LEVELS - 1;

    typedef enum logic [CREDIT_LEVELS-1:0] {
        CR_0C  = CREDIT_LEVELS'(1),
        CR_5C  = CREDIT_LEVELS'(2),
        CR_10C = CREDIT_LEVELS'(4),
        CR_15C = CREDIT_LEVELS'(8)
    } credit_e;

    typedef enum logic [1:0] {
        COIN_NONE   = 2'd0,
        COIN_NICKEL = 2'd1,
        COIN_DIME   = 2'd2
    } coin_e;

endpackage

// File: rtl/coin_decode.sv
module coin_decode
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);

    // Both lines high resolves to a dime
    always_comb begin
        if (dime_i)
            coin_o = COIN_DIME;
        else if (nickel_i)
            coin_o = COIN_NICKEL;
        else
            coin_o = COIN_NONE;
    end

endmodule

// File: rtl/credit_next.sv
module credit_next
    import vend_pkg::*;
(
    input  credit_e cur_i,
    input  coin_e   coin_i,
    output credit_e nxt_o
);

    always_comb begin
        nxt_o = CR_0C;
        unique case (cur_i)
            CR_0C: begin
                case (coin_i)
                    COIN_NICKEL: nxt_o = CR_5C;
                    COIN_DIME:   nxt_o = CR_10C;
                    default:     nxt_o = CR_0C;
                endcase
            end
            CR_5C: begin
                case (coin_i)
                    COIN_NICKEL: nxt_o = CR_10C;
                    COIN_DIME:   nxt_o = CR_15C;
                    default:     nxt_o = CR_5C;
                endcase
            end
            CR_10C: begin
                // any coin completes the price; dime excess is dropped
                case (coin_i)
                    COIN_NICKEL: nxt_o = CR_15C;
                    COIN_DIME:   nxt_o = CR_15C;
                    default:     nxt_o = CR_10C;
                endcase
            end
            CR_15C:  nxt_o = CR_15C;
            default: nxt_o = CR_0C;
        endcase
    end

endmodule

// File: rtl/credit_reg.sv
module credit_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  credit_e nxt_i,
    output credit_e cur_o
);

    always_ff @(posedge clk) begin
        if (rst)
            cur_o <= CR_0C;
        else
            cur_o <= nxt_i;
    end

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic open_o,
    output logic state_bad_o
);

    coin_e                    coin;
    credit_e                  state_q;
    credit_e                  state_d;
    logic [CREDIT_LEVELS-1:0] state_bits;

    coin_decode u_coin_decode (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    credit_next u_credit_next (
        .cur_i  (state_q),
        .coin_i (coin),
        .nxt_o  (state_d)
    );

    credit_reg u_credit_reg (
        .clk   (clk),
        .rst   (rst),
        .nxt_i (state_d),
        .cur_o (state_q)
    );

    assign state_bits = state_q;

    // Outputs come straight from the state flip-flops
    always_comb begin
        open_o      = state_bits[TOP_IDX];
        state_bad_o = ($countones(state_bits) != 1);
    end

endmodule

// File: rtl/vend_checker.sv
module vend_checker
    import vend_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     nickel_i,
    input logic                     dime_i,
    input logic                     open_o,
    input logic                     state_bad_o,
    input logic [CREDIT_LEVELS-1:0] state_q
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b1;
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (state_q == CR_0C) && !open_o);

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        $onehot(state_q) && !state_bad_o);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        (!nickel_i && !dime_i) |=> $stable(state_q));

    p_nickel_step_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        (state_q == CR_0C && nickel_i && !dime_i) |=> (state_q == CR_5C));

    p_dime_step_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        (state_q == CR_0C && dime_i) |=> (state_q == CR_10C));

    p_overpay_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        (state_q == CR_10C && dime_i) |=> open_o);

    p_open_rise_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(open_o) |-> $past(nickel_i || dime_i));

    p_latch_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        open_o |=> open_o);

    p_both_lines_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        (state_q == CR_5C && nickel_i && dime_i) |=> open_o);

endmodule

bind coin_vend_ctrl vend_checker u_vend_checker (
    .clk         (clk),
    .rst         (rst),
    .nickel_i    (nickel_i),
    .dime_i      (dime_i),
    .open_o      (open_o),
    .state_bad_o (state_bad_o),
    .state_q     (state_bits)
);

// File: tb/coin_vend_ctrl_bench.sv
`timescale 1ns/1ps
module coin_vend_ctrl_bench;

    logic clk = 1'b0;
    logic rst = 1'b0;
    logic nickel_i = 1'b0;
    logic dime_i = 1'b0;
    logic open_o;
    logic state_bad_o;

    int checks = 0;
    int fails = 0;
    int model_cents = 0;
    string last_tag = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    coin_vend_ctrl u_coin_vend_ctrl (
        .clk         (clk),
        .rst         (rst),
        .nickel_i    (nickel_i),
        .dime_i      (dime_i),
        .open_o      (open_o),
        .state_bad_o (state_bad_o)
    );

    function automatic int next_cents(int cur, bit r, bit n, bit d);
        if (r) return 0;
        if (cur >= 15) return 15;
        if (d) return (cur + 10 > 15) ? 15 : cur + 10;
        if (n) return cur + 5;
        return cur;
    endfunction

    function automatic string tag_for(int cur, bit r, bit n, bit d);
        if (r) return "R1";
        if (cur >= 15) return "R8";
        if (n && d) return "R9";
        if (d && cur == 10) return "R6";
        if (d) return "R5";
        if (n) return "R4";
        return "R3";
    endfunction

    task automatic check_outputs();
        bit exp_open;
        exp_open = (model_cents >= 15);
        checks++;
        if (open_o !== exp_open) begin
            fails++;
            $display("FAIL %s/R7 open_o actual=%b expected=%b (credit %0d)",
                     last_tag, open_o, exp_open, model_cents);
        end
        checks++;
        if (state_bad_o !== 1'b0) begin
            fails++;
            $display("FAIL R2 state_bad_o actual=%b expected=0", state_bad_o);
        end
    endtask

    // Check the result of the previous cycle, then apply new inputs
    task automatic step(bit r, bit n, bit d);
        @(negedge clk);
        check_outputs();
        rst = r;
        nickel_i = n;
        dime_i = d;
        last_tag = tag_for(model_cents, r, n, d);
        model_cents = next_cents(model_cents, r, n, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        rst = 1'b1;
        model_cents = 0;
        last_tag = "R1";
        step(1, 0, 0);
        step(0, 0, 0);                    // R1 reset state
        // R4 three nickels
        step(0, 1, 0); step(0, 0, 0); step(0, 1, 0); step(0, 1, 0); step(0, 0, 0);
        // R8 coins after release are ignored
        step(0, 1, 0); step(0, 0, 1); step(0, 1, 1); step(0, 0, 0);
        // R1 reset clears
        step(1, 0, 0); step(0, 0, 0);
        // R5 dime then nickel; nickel then dime
        step(0, 0, 1); step(0, 0, 0); step(0, 1, 0); step(1, 0, 0);
        step(0, 1, 0); step(0, 0, 1); step(1, 0, 0);
        // R6 two dimes
        step(0, 0, 1); step(0, 0, 1); step(0, 0, 0); step(1, 0, 0);
        // R9 both lines then nickel must release
        step(0, 1, 1); step(0, 1, 0); step(0, 0, 0); step(1, 0, 0);
        // R3 long idle at 5 cents
        step(0, 1, 0);
        for (int i = 0; i < 6; i++) step(0, 0, 0);
        step(1, 0, 0);
        // random stream
        for (int i = 0; i < 3000; i++) begin
            bit r, n, d;
            int pick;
            r = ($urandom_range(0, 39) == 0);
            pick = $urandom_range(0, 9);
            n = (pick < 3) || (pick == 9);
            d = (pick >= 6);
            step(r, n, d);
        end
        step(0, 0, 0);
        @(negedge clk);
        check_outputs();
        finish_run();
    end

endmodule